// File: doc/BRIEF.md
# Configurable Clock Output Channel

This block drives one clock output of a multi-source clock generator. A 5-bit option code picks one of thirty divided versions of four source clocks: the crystal reference, a CPU PLL, a utility PLL and a system PLL. The channel can also be switched off. The divided output has an exact 50% duty cycle for every divisor, odd divisors such as 3, 5 and 13 included. When the option code changes, the channel moves to the new setting without producing a shortened high pulse.

The block runs on one fast clock, `clk`. Each source clock reaches it as a strobe on `src_tick`. A one-cycle pulse on bit i marks one edge of source i, rising or falling, so two strobes make one source period. Bit 0 is the reference, bit 1 the CPU PLL, bit 2 the utility PLL and bit 3 the system PLL. A divide-by-N output stays high for N source edges and then low for N source edges. A parameter sets the channel kind, and the kind decides which codes the channel accepts and whether code 4 is substituted.

Top module: `clk_option_channel`

## Requirements
- R1: While `rst_n` is low, and after it is released with code 0, `clk_out` is low whatever `opt_code` holds.
- R2: Codes 1, 2, 3 and 4 select the reference (tick bit 0) divided by 1, 2, 4 and 8.
- R3: Codes 5 to 8 select the CPU PLL (tick bit 1) divided by 1, 2, 4 and 8. Codes 9 to 12 select the utility PLL (tick bit 2) divided by 1, 2, 4 and 8.
- R4: Codes 13 to 30, in rising order, select the system PLL (tick bit 3) divided by 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96 and 104.
- R5: In steady state, each high phase and each low phase of `clk_out` lasts exactly N strobes of the selected source, for odd N as well as even N.
- R6: On a channel of kind KIND_ALT_D, code 4 selects the reference divided by 3, not by 8. All other codes behave as on a general channel.
- R7: A channel of kind KIND_SYS_ONLY accepts only codes 14 to 16. KIND_CPU_ONLY accepts only 5 to 7, KIND_REF_ONLY accepts only 1, and the general kinds accept 1 to 30. Any code a channel does not accept acts as off.
- R8: Code 0 means off, and `clk_out` then stays low.
- R9: A code change that arrives while `clk_out` is high leaves the current high phase at its full length. The new code is loaded at the first `clk` edge that sees `clk_out` low, and that edge's strobe is ignored. The low phase that follows therefore lasts one `clk` cycle plus N strobes.
- R10: Two channels on the same source that load their codes at the same edge stay related: every transition of the slower output falls in the same cycle as a transition of the faster one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_code | input | 5 | Requested option code (0 = off) |
| src_tick | input | 4 | Edge strobes: reference, CPU PLL, utility PLL, system PLL |
| clk_out | output | 1 | Divided clock output |

## Verification
Each source strobes at its own rate: the reference every 5 cycles, the CPU PLL every 2, the utility PLL every 3 and the system PLL every cycle. A source mix-up therefore shows up as a wrong phase length. The odd divisors 3, 5 and 13 catch a divider that counts only one edge type, which would give unequal high and low phases. Changing the code in the middle of a high phase catches a switch that cuts the pulse short or loads before the output is low. Two channels started together catch a divider that loads out of phase. The D substitution and the narrow system-only channel catch a decoder that ignores the channel kind and lets forbidden codes run.

// File: rtl/clk_option_pkg.sv
package clk_option_pkg;

    localparam int CODE_W = 5;
    localparam int HALF_W = 7;
    localparam int SRC_N  = 4;
    localparam int SRC_W  = $clog2(SRC_N);

    typedef enum logic [2:0] {
        KIND_GENERAL,
        KIND_ALT_D,
        KIND_SYS_ONLY,
        KIND_CPU_ONLY,
        KIND_REF_ONLY
    } chan_kind_e;

    localparam logic [SRC_W-1:0] SRC_REF  = SRC_W'(0);
    localparam logic [SRC_W-1:0] SRC_CPU  = SRC_W'(1);
    localparam logic [SRC_W-1:0] SRC_UTIL = SRC_W'(2);
    localparam logic [SRC_W-1:0] SRC_SYS  = SRC_W'(3);

    typedef struct packed {
        logic              on;
        logic [SRC_W-1:0]  src;
        logic [HALF_W-1:0] half;
    } opt_cfg_t;

    // Which codes a channel kind accepts (R7).
    function automatic logic code_legal(logic [CODE_W-1:0] code, chan_kind_e kind);
        case (kind)
            KIND_SYS_ONLY: return (code >= 5'd14) && (code <= 5'd16);
            KIND_CPU_ONLY: return (code >= 5'd5) && (code <= 5'd7);
            KIND_REF_ONLY: return code == 5'd1;
            default:       return (code >= 5'd1) && (code <= 5'd30);
        endcase
    endfunction

    // Four-way power-of-two divisor for codes within a group of four.
    function automatic logic [HALF_W-1:0] pow_div(logic [1:0] idx);
        case (idx)
            2'd0:    return HALF_W'(1);
            2'd1:    return HALF_W'(2);
            2'd2:    return HALF_W'(4);
            default: return HALF_W'(8);
        endcase
    endfunction

    function automatic opt_cfg_t decode_opt(logic [CODE_W-1:0] code, chan_kind_e kind);
        opt_cfg_t cfg;
        logic [CODE_W-1:0] rel;
        cfg = '0;
        rel = '0;
        if (code_legal(code, kind)) begin
            cfg.on = 1'b1;
            if (code <= 5'd4) begin
                rel      = code - 5'd1;
                cfg.src  = SRC_REF;
                cfg.half = pow_div(rel[1:0]);
                if (kind == KIND_ALT_D && code == 5'd4) cfg.half = HALF_W'(3);
            end else if (code <= 5'd8) begin
                rel      = code - 5'd5;
                cfg.src  = SRC_CPU;
                cfg.half = pow_div(rel[1:0]);
            end else if (code <= 5'd12) begin
                rel      = code - 5'd9;
                cfg.src  = SRC_UTIL;
                cfg.half = pow_div(rel[1:0]);
            end else begin
                cfg.src = SRC_SYS;
                case (code)
                    5'd13:   cfg.half = HALF_W'(1);
                    5'd14:   cfg.half = HALF_W'(2);
                    5'd15:   cfg.half = HALF_W'(3);
                    5'd16:   cfg.half = HALF_W'(4);
                    5'd17:   cfg.half = HALF_W'(5);
                    5'd18:   cfg.half = HALF_W'(6);
                    5'd19:   cfg.half = HALF_W'(8);
                    5'd20:   cfg.half = HALF_W'(10);
                    5'd21:   cfg.half = HALF_W'(12);
                    5'd22:   cfg.half = HALF_W'(13);
                    5'd23:   cfg.half = HALF_W'(20);
                    5'd24:   cfg.half = HALF_W'(24);
                    5'd25:   cfg.half = HALF_W'(26);
                    5'd26:   cfg.half = HALF_W'(40);
                    5'd27:   cfg.half = HALF_W'(48);
                    5'd28:   cfg.half = HALF_W'(52);
                    5'd29:   cfg.half = HALF_W'(96);
                    default: cfg.half = HALF_W'(104);
                endcase
            end
        end
        return cfg;
    endfunction

endpackage

// File: rtl/clk_option_decode.sv
module clk_option_decode
    import clk_option_pkg::*;
#(
    parameter chan_kind_e KIND = KIND_GENERAL
) (
    input  logic [CODE_W-1:0] code,
    output opt_cfg_t          cfg
);

    // Codes map to source and half-period length; R2, R3, R4, R6, R7, R8.
    always_comb begin
        cfg = decode_opt(code, KIND);
    end

endmodule

// File: rtl/clk_option_switch.sv
module clk_option_switch #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_req,
    input  logic              out_level,
    output logic [CODE_W-1:0] code_act,
    output logic              restart
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } sw_st_t;

    sw_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = (code_req != st_q.code) && !out_level;
        if (restart) st_d.code = code_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_act = st_q.code;

    // R9: the active code never moves while the output is high.
    a_r9_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        out_level |=> $stable(code_act));

    // R9: any change of the active code follows a low output.
    a_r9_change_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (code_act != $past(code_act)) |-> !$past(out_level));

endmodule

// File: rtl/clk_option_halfdiv.sv
module clk_option_halfdiv #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              on,
    input  logic [HALF_W-1:0] half,
    input  logic              tick,
    output logic              lvl
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } div_st_t;

    div_st_t st_d, st_q;

    // Counting every source edge gives N edges per phase: 50% for odd N too (R5).
    always_comb begin
        st_d = st_q;
        if (restart || !on) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == half - HALF_W'(1)) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;

    // R8: an off channel is low from the next cycle on.
    a_r8_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> !lvl);

    // R5: the edge counter stays inside the selected half period.
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> (st_q.cnt < half));

    // R5: the output rises only on a source edge.
    a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl) |-> $past(tick));

endmodule

// File: rtl/clk_option_channel.sv
module clk_option_channel
    import clk_option_pkg::*;
#(
    parameter chan_kind_e KIND = KIND_GENERAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] opt_code,
    input  logic [SRC_N-1:0]  src_tick,
    output logic              clk_out
);

    logic [CODE_W-1:0] code_act;
    logic              restart;
    logic              tick_sel;
    logic              lvl;
    opt_cfg_t          cfg;

    clk_option_switch #(.CODE_W(CODE_W)) u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_req  (opt_code),
        .out_level (lvl),
        .code_act  (code_act),
        .restart   (restart)
    );

    clk_option_decode #(.KIND(KIND)) u_decode (
        .code (code_act),
        .cfg  (cfg)
    );

    assign tick_sel = src_tick[cfg.src];

    clk_option_halfdiv #(.HALF_W(HALF_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .on      (cfg.on),
        .half    (cfg.half),
        .tick    (tick_sel),
        .lvl     (lvl)
    );

    assign clk_out = lvl;

    // R7: an output that is high belongs to a code this kind accepts.
    a_r7_high_only_if_legal: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> code_legal(code_act, KIND));

endmodule

// File: tb/clk_option_channel_bench.sv
module clk_option_channel_bench;
    import clk_option_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] code_g = '0, code_d = '0, code_f = '0;
    logic [3:0] src_tick = '0;
    logic       out_g, out_d, out_f;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;

    always #4 clk = ~clk;

    // Strobe rates: reference 5, CPU 2, utility 3, system 1 cycles per edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        src_tick[0] = (cyc % 5 == 0);
        src_tick[1] = (cyc % 2 == 0);
        src_tick[2] = (cyc % 3 == 0);
        src_tick[3] = 1'b1;
    end

    clk_option_channel #(.KIND(KIND_GENERAL)) u_clk_option_channel (
        .clk(clk), .rst_n(rst_n), .opt_code(code_g), .src_tick(src_tick), .clk_out(out_g));
    clk_option_channel #(.KIND(KIND_ALT_D)) u_clk_option_channel_d (
        .clk(clk), .rst_n(rst_n), .opt_code(code_d), .src_tick(src_tick), .clk_out(out_d));
    clk_option_channel #(.KIND(KIND_SYS_ONLY)) u_clk_option_channel_f (
        .clk(clk), .rst_n(rst_n), .opt_code(code_f), .src_tick(src_tick), .clk_out(out_f));

    // inst: 0 general, 1 D kind, 2 system-only; hi: expected phase in cycles, 0 = off.
    typedef struct packed {
        logic [1:0] inst;
        logic [4:0] code;
        logic [7:0] hi;
    } vec_t;

    localparam vec_t VECS [0:22] = '{
        '{2'd0, 5'd1,  8'd5},   '{2'd0, 5'd2,  8'd10},  '{2'd0, 5'd3,  8'd20},
        '{2'd0, 5'd4,  8'd40},  '{2'd0, 5'd5,  8'd2},   '{2'd0, 5'd8,  8'd16},
        '{2'd0, 5'd9,  8'd3},   '{2'd0, 5'd12, 8'd24},  '{2'd0, 5'd13, 8'd1},
        '{2'd0, 5'd15, 8'd3},   '{2'd0, 5'd17, 8'd5},   '{2'd0, 5'd22, 8'd13},
        '{2'd0, 5'd25, 8'd26},  '{2'd0, 5'd29, 8'd96},  '{2'd0, 5'd30, 8'd104},
        '{2'd0, 5'd0,  8'd0},   '{2'd0, 5'd31, 8'd0},   '{2'd1, 5'd4,  8'd15},
        '{2'd1, 5'd1,  8'd5},   '{2'd2, 5'd15, 8'd3},   '{2'd2, 5'd16, 8'd4},
        '{2'd2, 5'd13, 8'd0},   '{2'd2, 5'd4,  8'd0}
    };

    function automatic logic sel_out(int i);
        case (i)
            0:       return out_g;
            1:       return out_d;
            default: return out_f;
        endcase
    endfunction

    function automatic string req_of(int inst, int code, int hi);
        if (hi == 0) return (code == 0) ? "R8" : "R7";
        if (inst == 1 && code == 4) return "R6";
        if (inst == 2) return "R7";
        if (code <= 4) return "R2";
        if (code <= 12) return "R3";
        return "R4";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_code(int inst, logic [4:0] c);
        @(negedge clk);
        case (inst)
            0:       code_g = c;
            1:       code_d = c;
            default: code_f = c;
        endcase
    endtask

    task automatic all_off();
        @(negedge clk);
        code_g = '0;
        code_d = '0;
        code_f = '0;
        repeat (230) @(negedge clk);
    endtask

    task automatic wait_rise(int inst, output bit ok);
        logic prev, cur;
        ok = 1'b0;
        prev = sel_out(inst);
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            cur = sel_out(inst);
            if (!prev && cur) begin
                ok = 1'b1;
                return;
            end
            prev = cur;
        end
    endtask

    // Called on the first high sample; returns the high run and the following low run.
    task automatic measure(int inst, output int hi, output int lo);
        hi = 1;
        lo = 0;
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            if (sel_out(inst)) hi++;
            else break;
        end
        lo = 1;
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            if (!sel_out(inst)) lo++;
            else break;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit ok;
        int hi_m, lo_m, ones, bad, tg, hcnt, lcnt;
        logic pg, pd;

        // R1: output low during reset with a live code requested.
        @(negedge clk);
        code_g = 5'd13;
        code_d = 5'd1;
        code_f = 5'd15;
        repeat (4) @(negedge clk);
        check("R1", out_g, 0);
        check("R1", out_d, 0);
        check("R1", out_f, 0);
        code_g = '0;
        code_d = '0;
        code_f = '0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1", out_g | out_d | out_f, 0);

        // Table walk: R2, R3, R4, R5, R6, R7, R8.
        for (int v = 0; v < 23; v++) begin
            all_off();
            set_code(int'(VECS[v].inst), VECS[v].code);
            if (VECS[v].hi == 0) begin
                ones = 0;
                for (int n = 0; n < 300; n++) begin
                    @(negedge clk);
                    if (sel_out(int'(VECS[v].inst))) ones++;
                end
                check(req_of(int'(VECS[v].inst), int'(VECS[v].code), 0), ones, 0);
            end else begin
                wait_rise(int'(VECS[v].inst), ok);
                if (!ok) begin
                    check(req_of(int'(VECS[v].inst), int'(VECS[v].code), int'(VECS[v].hi)),
                          -1, int'(VECS[v].hi));
                end else begin
                    measure(int'(VECS[v].inst), hi_m, lo_m);
                    check(req_of(int'(VECS[v].inst), int'(VECS[v].code), int'(VECS[v].hi)),
                          hi_m, int'(VECS[v].hi));
                    check("R5", lo_m, int'(VECS[v].hi));
                end
            end
        end

        // R9: change during a high phase of system/10 to system/2.
        all_off();
        set_code(0, 5'd20);
        wait_rise(0, ok);
        check("R9", int'(ok), 1);
        hcnt = 1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            if (out_g) hcnt++;
        end
        code_g = 5'd14;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (out_g) hcnt++;
            else break;
        end
        check("R9", hcnt, 10);
        lcnt = 1;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (!out_g) lcnt++;
            else break;
        end
        check("R9", lcnt, 3);
        measure(0, hi_m, lo_m);
        check("R9", hi_m, 2);

        // R10: system/2 and system/4 started on the same edge.
        all_off();
        @(negedge clk);
        code_g = 5'd14;
        code_d = 5'd16;
        pg = out_g;
        pd = out_d;
        bad = 0;
        tg = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (out_d != pd) begin
                tg++;
                if (out_g == pg) bad++;
            end
            pg = out_g;
            pd = out_d;
        end
        check("R10", bad, 0);
        check("R10", int'(tg > 40), 1);

        summary();
    end

endmodule